// File: doc/BRIEF.md
# Accumulator ALU with carry flag

This block is the arithmetic and logic unit of an 8-bit accumulator machine. It owns the accumulator register and a one-bit carry/borrow flag. On each cycle where the start strobe is high it reads a 4-bit operation code and a memory operand byte. It then combines the operand with the present accumulator and flag, and writes the new accumulator and flag back into its registers. On every other cycle both registers hold their values.

The operations are OR, AND, XOR and a plain load. There are addition with and without incoming carry, and subtraction in two directions: operand minus accumulator, and accumulator minus operand. Each subtraction comes with and without a borrow. There are also four shifts, two of which rotate through the flag. For subtraction the flag is an inverted borrow: 1 means no borrow occurred. Operand fetch, pointer updates and instruction decoding belong to the surrounding machine.

Top module: `acc_alu`

## Requirements
- R1: After reset, acc is 0x00 and flag is 0.
- R2: While start is low, acc and flag keep their values whatever op and operand carry.
- R3: Op codes 14 and 15 are reserved; with start high they leave acc and flag unchanged.
- R4: Op 0 writes operand OR acc, op 1 operand AND acc, op 2 operand XOR acc, into acc; flag is unchanged.
- R5: Op 3 copies operand into acc; flag is unchanged.
- R6: Op 4 writes the 8-bit sum acc+operand to acc and the carry out to flag; op 5 also adds the incoming flag.
- R7: Op 6 computes operand minus acc; op 7 computes operand minus acc minus 1 when the incoming flag is 0 (no extra 1 when it is 1). The low 8 bits go to acc, and flag is 1 exactly when the true difference is not negative.
- R8: Op 8 computes acc minus operand; op 9 computes acc minus operand minus 1 when the incoming flag is 0. The low 8 bits go to acc, and flag is 1 exactly when the true difference is not negative.
- R9: Op 10 shifts acc right by one: the old bit 0 goes to flag and bit 7 becomes 0. Op 11 is the same, except that bit 7 takes the old flag.
- R10: Op 12 shifts acc left by one: the old bit 7 goes to flag and bit 0 becomes 0. Op 13 is the same, except that bit 0 takes the old flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Perform the selected operation this cycle |
| op | input | 4 | Operation code |
| operand | input | W | Memory operand byte |
| acc | output | W | Accumulator register |
| flag | output | 1 | Carry/borrow flag register |

## Verification
The flag is read as an input and overwritten as an output within one operation. The carrying adds, the borrowing subtractions and the two rotating shifts therefore consume the old flag and produce the new one on the same edge. The sweep forces both flag values before every operation on a grid of accumulator and operand values that includes 0x00, 0xFF and equal pairs. It then compares acc and flag one edge later against arithmetic done on signed integers in the bench. The same step also checks that a cycle with start low right after the operation leaves both registers untouched.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic         flag
);

  localparam logic [3:0] OP_OR   = 4'd0;
  localparam logic [3:0] OP_AND  = 4'd1;
  localparam logic [3:0] OP_XOR  = 4'd2;
  localparam logic [3:0] OP_LD   = 4'd3;
  localparam logic [3:0] OP_ADD  = 4'd4;
  localparam logic [3:0] OP_ADC  = 4'd5;
  localparam logic [3:0] OP_SD   = 4'd6;
  localparam logic [3:0] OP_SDB  = 4'd7;
  localparam logic [3:0] OP_SM   = 4'd8;
  localparam logic [3:0] OP_SMB  = 4'd9;
  localparam logic [3:0] OP_SHR  = 4'd10;
  localparam logic [3:0] OP_SHRC = 4'd11;
  localparam logic [3:0] OP_SHL  = 4'd12;
  localparam logic [3:0] OP_SHLC = 4'd13;

  logic [W-1:0] add_a, add_b, nxt_acc;
  logic         add_cin, nxt_flag;
  logic [W:0]   sum;

  always_comb begin
    add_a   = acc;
    add_b   = operand;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC:        add_cin = flag;
      OP_SD:  begin add_a = operand; add_b = ~acc;     add_cin = 1'b1; end
      OP_SDB: begin add_a = operand; add_b = ~acc;     add_cin = flag; end
      OP_SM:  begin                  add_b = ~operand; add_cin = 1'b1; end
      OP_SMB: begin                  add_b = ~operand; add_cin = flag; end
      default: ;
    endcase
  end

  assign sum = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, add_cin};

  always_comb begin
    nxt_acc  = acc;
    nxt_flag = flag;
    case (op)
      OP_OR:   nxt_acc = acc | operand;
      OP_AND:  nxt_acc = acc & operand;
      OP_XOR:  nxt_acc = acc ^ operand;
      OP_LD:   nxt_acc = operand;
      OP_ADD, OP_ADC, OP_SD, OP_SDB, OP_SM, OP_SMB:
               {nxt_flag, nxt_acc} = sum;
      OP_SHR:  begin nxt_acc = {1'b0, acc[W-1:1]}; nxt_flag = acc[0];   end
      OP_SHRC: begin nxt_acc = {flag, acc[W-1:1]}; nxt_flag = acc[0];   end
      OP_SHL:  begin nxt_acc = {acc[W-2:0], 1'b0}; nxt_flag = acc[W-1]; end
      OP_SHLC: begin nxt_acc = {acc[W-2:0], flag}; nxt_flag = acc[W-1]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      flag <= 1'b0;
    end else if (start) begin
      acc  <= nxt_acc;
      flag <= nxt_flag;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(acc) && $stable(flag));

  p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && op >= 4'd14 |=> $stable(acc) && $stable(flag));

  p_logic_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && (op == OP_OR || op == OP_AND || op == OP_XOR) |=> $stable(flag));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == OP_LD |=> acc == $past(operand) && $stable(flag));

  p_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == OP_ADD |=>
      {flag, acc} == {1'b0, $past(acc)} + {1'b0, $past(operand)});

  p_sm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == OP_SM |=>
      acc == $past(acc) - $past(operand) && flag == ($past(acc) >= $past(operand)));

  p_shr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == OP_SHRC |=> acc[W-1] == $past(flag) && flag == $past(acc[0]));

  p_shl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == OP_SHLC |=> acc[0] == $past(flag) && flag == $past(acc[W-1]));

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc;
  logic       flag;

  int checks = 0;
  int errors = 0;

  acc_alu #(.W(8)) i_acc_alu (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .operand(operand), .acc(acc), .flag(flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2:   return "R4";
      4'd3:               return "R5";
      4'd4, 4'd5:         return "R6";
      4'd6, 4'd7:         return "R7";
      4'd8, 4'd9:         return "R8";
      4'd10, 4'd11:       return "R9";
      4'd12, 4'd13:       return "R10";
      default:            return "R3";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input int d, input int f, input int m,
                       output logic [7:0] rd, output logic rf);
    int t;
    rd = d[7:0];
    rf = f[0];
    case (o)
      4'd0: rd = 8'(d | m);
      4'd1: rd = 8'(d & m);
      4'd2: rd = 8'(d ^ m);
      4'd3: rd = 8'(m);
      4'd4: begin t = d + m;     rd = 8'(t); rf = (t > 255); end
      4'd5: begin t = d + m + f; rd = 8'(t); rf = (t > 255); end
      4'd6: begin t = m - d;           rd = 8'(t & 255); rf = (t >= 0); end
      4'd7: begin t = m - d - (1 - f); rd = 8'(t & 255); rf = (t >= 0); end
      4'd8: begin t = d - m;           rd = 8'(t & 255); rf = (t >= 0); end
      4'd9: begin t = d - m - (1 - f); rd = 8'(t & 255); rf = (t >= 0); end
      4'd10: begin rd = 8'(d / 2);           rf = d[0]; end
      4'd11: begin rd = 8'(d / 2 + 128 * f); rf = d[0]; end
      4'd12: begin rd = 8'((d * 2) & 255);     rf = d[7]; end
      4'd13: begin rd = 8'((d * 2) & 255 | f); rf = d[7]; end
      default: ;
    endcase
  endtask

  task automatic step(input logic s, input logic [3:0] o, input logic [7:0] m);
    @(negedge clk);
    start = s; op = o; operand = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check(input string req, input logic [7:0] ed, input logic ef);
    checks++;
    if (acc !== ed || flag !== ef) begin
      errors++;
      $display("FAIL %s: acc=%02h flag=%0b expected acc=%02h flag=%0b", req, acc, flag, ed, ef);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 1'b0);

    for (int o = 0; o < 16; o++) begin
      for (int f = 0; f < 2; f++) begin
        for (int di = 0; di < 16; di++) begin
          for (int mi = 0; mi < 16; mi++) begin
            int d = di * 17;
            int m = mi * 17;
            logic [7:0] ed;
            logic ef;
            step(1'b1, 4'd3, f[0] ? 8'h80 : 8'h00);
            step(1'b1, 4'd12, 8'h00);
            step(1'b1, 4'd3, 8'(d));
            check("R5", 8'(d), f[0]);
            model(4'(o), d, f, m, ed, ef);
            step(1'b1, 4'(o), 8'(m));
            check(req_of(4'(o)), ed, ef);
            step(1'b0, 4'(o ^ 4), 8'(~m));
            check("R2", ed, ef);
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule